// File: doc/BRIEF.md
# Blit Parameter Register Bank with Launch

This block holds the parameter set of a two-dimensional block-transfer engine: eleven 32-bit registers that software fills through a small memory-mapped access port. Byte, halfword and word accesses are accepted. Each wider access is split into little-endian byte lanes, so lane i reaches offset (address + i). Only the low 12 address bits are decoded. Offsets beyond the bank read as zero and ignore writes.

Writing the top byte of the size register (offset 0x23) launches an operation when the engine is idle. The block then copies the complete parameter set into a running shadow copy and loads a source and a destination row count from the height field. It holds busy high for a programmable number of cycles and then emits a one-cycle completion pulse towards an interrupt controller. The shadow outputs stay frozen until the next launch, so a downstream pixel engine can run from them while software reprograms the bank.

A small status word shows bit 31 of the control register (offset 0x10) alongside the busy flag.

Top module: `blit_param_bank`

## Requirements
- R1: After reset every bank byte reads zero, the shadow copy and both row counts are zero, and busy and the completion pulse are low.
- R2: accSize encodes 0 = byte, 1 = halfword, 2 or 3 = word. Byte lane i (accWdata/accRdata bits 8i+7:8i) maps to offset (address + i) modulo 4096. A write updates exactly those lanes, and a read returns them, with lanes beyond the access size reading zero.
- R3: Only address bits 11:0 are decoded, so addresses that differ only above bit 11 reach the same byte.
- R4: A lane whose offset is 0x2C or above reads zero and its write has no effect on the bank.
- R5: A write whose lanes include offset 0x23 while busy is low launches an operation. In the next cycle busy is high and the shadow copy equals the bank including every byte of that write. Shadow byte k sits at shadowRegs bits 8k+7:8k.
- R6: On launch the source row count takes the height field (bytes 0x22 and 0x23, little-endian). The destination row count takes the same value, or 1 when the height is zero.
- R7: Busy stays high for exactly max(opLatency, 1) cycles after the launch edge. The completion pulse is high for one cycle, the first cycle in which busy is low again.
- R8: A write to offset 0x23 while busy updates the bank but does not relaunch. The shadow copy, the row counts and the remaining busy time are unchanged.
- R9: statusBits bit 0 equals bit 7 of bank byte 0x13 (bit 31 of the control register), and statusBits bit 1 equals busy.
- R10: Writes that do not launch leave the shadow copy and row counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Access valid this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | ADDR_W (32) | Byte address, low 12 bits decoded |
| accSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| accWdata | input | 32 | Write data, lane i to offset address+i |
| accRdata | output | 32 | Combinational read data |
| opLatency | input | CNT_W (16) | Busy duration sampled at launch |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-cycle completion event |
| statusBits | output | 2 | {busy, control bit 31} |
| shadowRegs | output | 352 | Running copy of all eleven registers |
| srcRows | output | 16 | Running source row count |
| dstRows | output | 16 | Running destination row count |

## Verification
The assertions assume that accSize, accAddr and accWdata are steady around each clock edge. They also assume that opLatency matters only on the launch cycle, and that reset is held for at least one edge before the first access. The bench drives every input on the falling edge and keeps opLatency small so that runs stay short. Random addresses cover offsets 0 to 63 with random upper bits. Whenever a random write happens to hit the launch byte, the bench waits out the complete operation before the next access, so the model's idle/busy view always matches the block's.

// File: rtl/blit_bank_pkg.sv
`timescale 1ns/1ps
package blit_bank_pkg;
  localparam int NUM_REGS   = 11;
  localparam int BANK_BYTES = NUM_REGS * 4;
  localparam int IDX_W      = $clog2(BANK_BYTES);
  localparam int LANES      = 4;
  localparam int DEC_W      = 12;
  localparam int ROW_W      = 16;
  localparam int TRIG_BYTE  = 'h23;
  localparam int HEIGHT_LO  = 'h22;
  localparam int CTRL_TOP   = 'h13;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0]            laneHit;
    logic [LANES-1:0][IDX_W-1:0] laneIdx;
    logic                        doWrite;
    logic                        launch;
  } bankStrobe_t;
endpackage

// File: rtl/blit_bank_ctrl.sv
`timescale 1ns/1ps
module blit_bank_ctrl
  import blit_bank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accEn,
  input  logic                 accWrite,
  input  logic [DEC_W-1:0]     accOff,
  input  logic [1:0]           accSize,
  input  logic [CNT_W-1:0]     opLatency,
  output bankStrobe_t          strobe,
  output logic                 busy,
  output logic                 donePulse
);
  logic [LANES-1:0][DEC_W-1:0] laneOff;
  logic [2:0]                  nBytes;
  logic                        trigHit;
  logic                        busyQ, doneQ;
  logic [CNT_W-1:0]            cntQ;

  always_comb begin
    unique case (accSize_e'(accSize))
      SZ_BYTE: nBytes = 3'd1;
      SZ_HALF: nBytes = 3'd2;
      default: nBytes = 3'd4;
    endcase
  end

  always_comb begin
    trigHit = 1'b0;
    strobe  = '0;
    for (int i = 0; i < LANES; i++) begin
      laneOff[i]           = accOff + DEC_W'(i);
      strobe.laneIdx[i]    = laneOff[i][IDX_W-1:0];
      strobe.laneHit[i]    = (i < int'(nBytes)) && (laneOff[i] < DEC_W'(BANK_BYTES));
      if (strobe.laneHit[i] && laneOff[i] == DEC_W'(TRIG_BYTE))
        trigHit = 1'b1;
    end
    strobe.doWrite = accEn && accWrite;
    strobe.launch  = accEn && accWrite && trigHit && !busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.launch) begin
        busyQ <= 1'b1;
        cntQ  <= (opLatency == '0) ? CNT_W'(1) : opLatency;
      end else if (busyQ) begin
        if (cntQ == CNT_W'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ - CNT_W'(1);
        end
      end
    end
  end

  assign busy      = busyQ;
  assign donePulse = doneQ;

  // R7: completion only ever follows a busy cycle and coincides with idle
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));

  // R7: the completion event lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R5: a launch makes the engine busy in the following cycle
  p_launch_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> busy);
endmodule

// File: rtl/blit_bank_regs.sv
`timescale 1ns/1ps
module blit_bank_regs
  import blit_bank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobe_t               strobe,
  input  logic [LANES*8-1:0]        accWdata,
  output logic [LANES*8-1:0]        accRdata,
  output logic [BANK_BYTES*8-1:0]   shadowRegs,
  output logic [ROW_W-1:0]          srcRows,
  output logic [ROW_W-1:0]          dstRows,
  output logic                      ctrlTopBit
);
  logic [BANK_BYTES-1:0][7:0] bankQ, bankNext, shadowQ;
  logic [ROW_W-1:0]           heightNext;
  logic [ROW_W-1:0]           srcRowsQ, dstRowsQ;

  always_comb begin
    bankNext = bankQ;
    if (strobe.doWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (strobe.laneHit[i])
          bankNext[strobe.laneIdx[i]] = accWdata[8*i +: 8];
      end
    end
  end

  assign heightNext = {bankNext[HEIGHT_LO+1], bankNext[HEIGHT_LO]};

  always_comb begin
    for (int i = 0; i < LANES; i++)
      accRdata[8*i +: 8] = strobe.laneHit[i] ? bankQ[strobe.laneIdx[i]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ    <= '0;
      shadowQ  <= '0;
      srcRowsQ <= '0;
      dstRowsQ <= '0;
    end else begin
      bankQ <= bankNext;
      if (strobe.launch) begin
        shadowQ  <= bankNext;
        srcRowsQ <= heightNext;
        dstRowsQ <= (heightNext == '0) ? ROW_W'(1) : heightNext;
      end
    end
  end

  assign shadowRegs = shadowQ;
  assign srcRows    = srcRowsQ;
  assign dstRows    = dstRowsQ;
  assign ctrlTopBit = bankQ[CTRL_TOP][7];

  // R6: the destination row count is never zero after a launch
  p_dst_rows_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> (dstRows != '0));

  // R6: the two row counts agree except for the zero-height case
  p_rows_relation_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> ((dstRows == srcRows) || (srcRows == '0 && dstRows == ROW_W'(1))));

  // R4: lanes outside the bank or the access size read as zero
  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    p_lane_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.laneHit[g] |-> (accRdata[8*g +: 8] == 8'h00));
  end
endmodule

// File: rtl/blit_param_bank.sv
`timescale 1ns/1ps
module blit_param_bank
  import blit_bank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    accEn,
  input  logic                    accWrite,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [1:0]              accSize,
  input  logic [31:0]             accWdata,
  output logic [31:0]             accRdata,
  input  logic [CNT_W-1:0]        opLatency,
  output logic                    busy,
  output logic                    donePulse,
  output logic [1:0]              statusBits,
  output logic [BANK_BYTES*8-1:0] shadowRegs,
  output logic [ROW_W-1:0]        srcRows,
  output logic [ROW_W-1:0]        dstRows
);
  bankStrobe_t strobe;
  logic        ctrlTopBit;
  logic        unusedAddrHi;

  assign unusedAddrHi = ^accAddr[ADDR_W-1:DEC_W];

  blit_bank_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accEn     (accEn),
    .accWrite  (accWrite),
    .accOff    (accAddr[DEC_W-1:0]),
    .accSize   (accSize),
    .opLatency (opLatency),
    .strobe    (strobe),
    .busy      (busy),
    .donePulse (donePulse)
  );

  blit_bank_regs i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .accWdata   (accWdata),
    .accRdata   (accRdata),
    .shadowRegs (shadowRegs),
    .srcRows    (srcRows),
    .dstRows    (dstRows),
    .ctrlTopBit (ctrlTopBit)
  );

  assign statusBits = {busy, ctrlTopBit};
endmodule

// File: tb/test_blit_param_bank.sv
`timescale 1ns/1ps
module test_blit_param_bank;
  localparam int NB = 44;

  logic         clk = 1'b0;
  logic         rstN;
  logic         accEn, accWrite;
  logic [31:0]  accAddr;
  logic [1:0]   accSize;
  logic [31:0]  accWdata, accRdata;
  logic [15:0]  opLatency;
  logic         busy, donePulse;
  logic [1:0]   statusBits;
  logic [NB*8-1:0] shadowRegs;
  logic [15:0]  srcRows, dstRows;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  bit mdlBusy = 0;
  logic [7:0] mdl [NB];
  logic [7:0] shd [NB];
  logic [15:0] expSrc, expDst;

  always #2.5 clk = ~clk;

  blit_param_bank i_blit_param_bank (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWrite(accWrite),
    .accAddr(accAddr), .accSize(accSize), .accWdata(accWdata),
    .accRdata(accRdata), .opLatency(opLatency), .busy(busy),
    .donePulse(donePulse), .statusBits(statusBits),
    .shadowRegs(shadowRegs), .srcRows(srcRows), .dstRows(dstRows)
  );

  function automatic int laneOff(logic [31:0] a, int i);
    return ((int'(a & 32'hFFF)) + i) & 'hFFF;
  endfunction

  function automatic int sizeBytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(logic [31:0] a, logic [1:0] sz);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int o = laneOff(a, i);
      if (i < sizeBytes(sz) && o < NB) r[8*i +: 8] = mdl[o];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [1:0] sz, logic [31:0] d, output bit launched);
    bit trig = 0;
    accEn = 1; accWrite = 1; accAddr = a; accSize = sz; accWdata = d;
    @(posedge clk);
    for (int i = 0; i < sizeBytes(sz); i++) begin
      int o = laneOff(a, i);
      if (o < NB) begin
        mdl[o] = d[8*i +: 8];
        if (o == 'h23) trig = 1;
      end
    end
    launched = trig && !mdlBusy;
    if (launched) begin
      for (int k = 0; k < NB; k++) shd[k] = mdl[k];
      expSrc = {mdl['h23], mdl['h22]};
      expDst = (expSrc == 16'd0) ? 16'd1 : expSrc;
      mdlBusy = 1;
    end
    @(negedge clk);
    accEn = 0; accWrite = 0;
  endtask

  task automatic rd(logic [31:0] a, logic [1:0] sz, string req);
    accEn = 1; accWrite = 0; accAddr = a; accSize = sz;
    #1;
    chk(req, accRdata, expRead(a, sz));
    accEn = 0;
    @(negedge clk);
  endtask

  task automatic chkShadow(string req);
    logic [NB*8-1:0] e;
    for (int k = 0; k < NB; k++) e[8*k +: 8] = shd[k];
    checks++;
    if (shadowRegs !== e) begin
      errs++;
      $display("FAIL %s shadow actual=%h expected=%h", req, shadowRegs, e);
    end
    chk(req, {srcRows, dstRows}, {expSrc, expDst});
  endtask

  task automatic expectRun(int left, string req);
    chk("R9", statusBits[1], 1'b1);
    for (int k = 0; k < left; k++) begin
      chk(req, {busy, donePulse}, 2'b10);
      @(posedge clk); @(negedge clk);
    end
    chk(req, {busy, donePulse}, 2'b01);
    @(posedge clk); @(negedge clk);
    chk(req, donePulse, 1'b0);
    mdlBusy = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit l;
    void'($urandom(32'd20240611));
    rstN = 0; accEn = 0; accWrite = 0; accAddr = 0; accSize = 0;
    accWdata = 0; opLatency = 16'd3;
    for (int k = 0; k < NB; k++) begin mdl[k] = 0; shd[k] = 0; end
    expSrc = 0; expDst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    for (int a = 0; a < NB; a += 4) rd(a, 2'd2, "R1");
    chk("R1", {busy, donePulse}, 2'b00);
    chkShadow("R1");

    // R2 lanes and sizes
    wr(32'h0, 2'd2, 32'h44332211, l);
    rd(32'h1, 2'd0, "R2");
    chk("R2", accRdata, 32'h00000022);
    rd(32'h2, 2'd1, "R2");
    wr(32'h5, 2'd1, 32'h1234BBAA, l);
    rd(32'h4, 2'd2, "R2");
    chk("R2", accRdata, 32'h00BBAA00);
    wr(32'h8, 2'd0, 32'hFFFFFF5C, l);
    rd(32'h8, 2'd3, "R2");

    // R3 upper address bits ignored
    wr(32'hABC01009, 2'd0, 32'h77, l);
    rd(32'h9, 2'd0, "R3");
    chk("R3", accRdata, 32'h77);
    rd(32'h70000009, 2'd0, "R3");

    // R4 out-of-range lanes
    wr(32'h2A, 2'd2, 32'hDDCCBBAA, l);
    rd(32'h2A, 2'd2, "R4");
    chk("R4", accRdata, 32'h0000BBAA);
    wr(32'h40, 2'd2, 32'hCAFEF00D, l);
    rd(32'h40, 2'd2, "R4");
    rd(32'hFFE, 2'd2, "R4");
    for (int a = 0; a < NB; a += 4) rd(a, 2'd2, "R4");

    // R9 status bit
    wr(32'h13, 2'd0, 32'h80, l);
    chk("R9", statusBits, 2'b01);
    wr(32'h13, 2'd0, 32'h7F, l);
    chk("R9", statusBits, 2'b00);

    // R5 R6 R7 launch via halfword, height 3
    opLatency = 16'd5;
    for (int a = 0; a < 'h20; a += 4) wr(a, 2'd2, $urandom, l);
    wr(32'h22, 2'd1, 32'h00000003, l);
    chk("R5", l, 1'b1);
    chkShadow("R5");
    chk("R6", {srcRows, dstRows}, {16'd3, 16'd3});
    expectRun(5, "R7");

    // R6 zero height, R7 zero latency treated as one
    opLatency = 16'd0;
    wr(32'h20, 2'd2, 32'h00000010, l);
    chkShadow("R6");
    chk("R6", {srcRows, dstRows}, {16'd0, 16'd1});
    expectRun(1, "R7");

    // R8 trigger while busy
    opLatency = 16'd6;
    wr(32'h23, 2'd0, 32'h01, l);
    chkShadow("R5");
    wr(32'h23, 2'd0, 32'h02, l);
    chk("R8", l, 1'b0);
    chkShadow("R8");
    expectRun(5, "R8");
    rd(32'h23, 2'd0, "R8");
    chk("R8", accRdata, 32'h02);

    // R10 plain writes leave the shadow alone
    wr(32'h0, 2'd2, 32'hA5A55A5A, l);
    wr(32'h18, 2'd1, 32'h0000BEEF, l);
    chkShadow("R10");

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = ($urandom & 32'hFFFFF000) | 32'($urandom_range(0, 63));
      logic [1:0]  sz = 2'($urandom_range(0, 3));
      opLatency = 16'($urandom_range(1, 4));
      if ($urandom_range(0, 1) == 1) begin
        wr(a, sz, $urandom, l);
        if (l) begin
          chkShadow("R5");
          expectRun(int'(opLatency), "R7");
        end else begin
          chkShadow("R10");
        end
      end else begin
        rd(a, sz, "R2");
      end
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule